// File: doc/BRIEF.md
# Bitfield Memory Operation Unit

This unit carries out one bit-field operation on byte-addressed, big-endian memory. A command gives a byte address, a signed bit offset, a field width and an operation code. From these the unit works out where the field starts and how many bytes it covers. It then asks the surrounding logic for a window of 1, 2, 4 or 8 bytes that contains the field. When the window data comes back, the unit extracts, inserts, inverts, clears, sets or scans the field. It returns a result word, a value for the N flag and, for operations that modify memory, the new window to be written back at the same address and size.

Bits are numbered from the most significant end: bit 0 of the field area is the top bit of the byte at the start address. The signed offset can move the start address backwards. A field can be 1 to 32 bits wide and can span up to five bytes.

The unit has three streams, each with a valid/ready handshake: a command stream, a read request/response pair toward memory, and a result stream. Only one command is in flight at a time. A transfer happens on a rising clock edge when both valid and ready are high. While valid is high and ready is low, the sender holds the payload unchanged. `cmd_ready` is high only when the unit is idle. The result stays on its outputs until `res_ready` accepts it.

Top module: `bfm_unit`

## Requirements
- R1: The effective width is `cmd_width` when it is nonzero and 32 when it is zero.
- R2: The field starts at absolute bit position `8*cmd_addr + cmd_ofs`, where `cmd_ofs` is signed. The start byte is that position divided by 8 with floor rounding, and the in-byte bit offset `b` is in the range 0 to 7.
- R3: The span is `n = (b + width - 1)/8 + 1` bytes. The request uses these address and size pairs (`rd_req_size` 0/1/2/3 means 1/2/4/8 bytes):
  - n=1: start byte, size 0.
  - n=2: start byte, size 1.
  - n=3: start byte, or start byte minus one if the start byte is odd, size 2.
  - n=4: start byte, size 2.
  - n=5: start byte with its two low bits cleared, size 3.
  The response holds the loaded bytes right-justified in `rd_rsp_data`, with the byte at the lowest address most significant.
- R4: Operation codes 0 and 1 put the field in `res_data`, sign-extended for code 0 and zero-extended for code 1. Code 7 behaves like code 1.
- R5: Code 2 (insert) writes the low `width` bits of `cmd_val` into the field. `res_flag` is then `cmd_val` shifted left by `32 - width`.
- R6: Codes 3, 4 and 5 invert, clear or set every field bit. No other bit of memory changes.
- R7: Code 6 returns in `res_data` the value `cmd_ofs` plus the number of leading zeros of the field, or `cmd_ofs + width` when the field is all zero.
- R8: Each command produces, in order, one read request, one accepted response and one result. The unit accepts no new command until the result has been taken. A stalled request or result holds its payload.
- R9: `res_wb_en` is 1 exactly for codes 2 to 5. `res_wb_addr` and `res_wb_size` equal the read request's address and size. Window bits outside the loaded size are zero.
- R10: For every code except 2, `res_flag` is the old field left-justified in 32 bits. For codes 2 to 5, `res_data` is the old field zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 32 | Base byte address |
| cmd_ofs | input | 32 | Signed bit offset |
| cmd_width | input | 5 | Field width, 0 means 32 |
| cmd_val | input | 32 | Insert value |
| rd_req_valid | output | 1 | Window read request |
| rd_req_ready | input | 1 | Request taken |
| rd_req_addr | output | 32 | Window byte address |
| rd_req_size | output | 2 | Window size code |
| rd_rsp_valid | input | 1 | Window data present |
| rd_rsp_ready | output | 1 | Unit waiting for data |
| rd_rsp_data | input | 64 | Window, right-justified |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_data | output | 32 | Extracted value, scan position or old field |
| res_flag | output | 32 | Left-justified N-flag source |
| res_wb_en | output | 1 | Window must be written back |
| res_wb_addr | output | 32 | Write-back byte address |
| res_wb_size | output | 2 | Write-back size code |
| res_wb_data | output | 64 | Modified window, right-justified |

## Verification
If the position state is wrong (start byte, bit offset or window offset), it first shows as a wrong `rd_req_addr` or `rd_req_size` in the cycle after the command is accepted. If the window is right but the bit offset is not, the error shows in the cycle after the response, as a shifted `res_data`/`res_flag`. It can also show as a changed memory byte outside the field once the window is written back. A wrong sequencing state shows as an overlap of the handshake phases, or as a payload that changes during a stall.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  parameter int ADDR_W  = 32;
  parameter int FIELD_W = 32;
  parameter int WIN_W   = 2 * FIELD_W;
  parameter int WOFS_W  = $clog2(WIN_W);
  parameter int LEN_W   = $clog2(FIELD_W) + 1;

  typedef enum logic [2:0] {
    OP_EXTS = 3'd0,
    OP_EXTU = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6,
    OP_RSV  = 3'd7
  } bf_op_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_OUT} bf_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [WOFS_W-1:0] wofs;
    logic [LEN_W-1:0]  len;
    logic [1:0]        size;
  } bf_geom_t;
endpackage

// File: rtl/bfm_geom.sv
module bfm_geom
  import bfm_pkg::*;
(
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [FIELD_W-1:0] bit_ofs,
  input  logic [LEN_W-2:0]   width,
  output bf_geom_t           geom
);
  logic signed [FIELD_W-1:0] ofs_s;
  logic signed [FIELD_W-1:0] disp;
  logic [ADDR_W-1:0]         start;
  logic [2:0]                bofs;
  logic [LEN_W-1:0]          len;
  logic [LEN_W:0]            last_bit;
  logic [2:0]                extra_bytes;

  always_comb begin
    ofs_s       = $signed(bit_ofs);
    disp        = ofs_s >>> 3;
    start       = base_addr + ADDR_W'(disp);
    bofs        = bit_ofs[2:0];
    len         = (width == '0) ? LEN_W'(FIELD_W) : {1'b0, width};
    last_bit    = {{(LEN_W-2){1'b0}}, bofs} + {1'b0, len} - 1'b1;
    extra_bytes = 3'(last_bit >> 3);

    geom.len  = len;
    geom.addr = start;
    geom.wofs = WOFS_W'(bofs);
    geom.size = 2'd0;
    case (extra_bytes)
      3'd0: begin
        geom.wofs = WOFS_W'(WIN_W - 8) + WOFS_W'(bofs);
        geom.size = 2'd0;
      end
      3'd1: begin
        geom.wofs = WOFS_W'(WIN_W - 16) + WOFS_W'(bofs);
        geom.size = 2'd1;
      end
      3'd2: begin
        geom.size = 2'd2;
        if (start[0]) begin
          geom.addr = start - 1'b1;
          geom.wofs = WOFS_W'(WIN_W - 24) + WOFS_W'(bofs);
        end else begin
          geom.wofs = WOFS_W'(WIN_W - 32) + WOFS_W'(bofs);
        end
      end
      3'd3: begin
        geom.wofs = WOFS_W'(WIN_W - 32) + WOFS_W'(bofs);
        geom.size = 2'd2;
      end
      default: begin
        geom.addr = {start[ADDR_W-1:2], 2'b00};
        geom.wofs = WOFS_W'(bofs) + WOFS_W'({start[1:0], 3'b000});
        geom.size = 2'd3;
      end
    endcase
  end
endmodule

// File: rtl/bfm_clz.sv
module bfm_clz #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  word,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (word[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bfm_alu.sv
module bfm_alu
  import bfm_pkg::*;
(
  input  bf_op_t             op,
  input  logic [WOFS_W-1:0]  wofs,
  input  logic [LEN_W-1:0]   len,
  input  logic [WIN_W-1:0]   win,
  input  logic [FIELD_W-1:0] val,
  input  logic [FIELD_W-1:0] ofs,
  output logic [WIN_W-1:0]   new_win,
  output logic [FIELD_W-1:0] res,
  output logic [FIELD_W-1:0] flag
);
  localparam int SH_W = WOFS_W + 1;

  logic [WIN_W-1:0]   all_ones;
  logic [WIN_W-1:0]   mask;
  logic [WIN_W-1:0]   lifted;
  logic [WIN_W-1:0]   ins_bits;
  logic [FIELD_W-1:0] old_lj;
  logic [FIELD_W-1:0] fld_zx;
  logic [FIELD_W-1:0] fld_sx;
  logic [LEN_W-1:0]   rsh;
  logic [SH_W-1:0]    top_sh;
  logic [LEN_W-1:0]   lead;

  bfm_clz #(.W(FIELD_W), .CW(LEN_W)) clz_i (.word(old_lj), .count(lead));

  always_comb begin
    all_ones = '1;
    top_sh   = SH_W'(WIN_W) - SH_W'(len);
    mask     = (all_ones << top_sh) >> wofs;
    lifted   = (win & mask) << wofs;
    old_lj   = lifted[WIN_W-1 -: FIELD_W];
    rsh      = LEN_W'(FIELD_W) - len;
    fld_zx   = old_lj >> rsh;
    fld_sx   = FIELD_W'($signed(old_lj) >>> rsh);
    ins_bits = ({{(WIN_W-FIELD_W){1'b0}}, val} << top_sh) >> wofs;

    new_win = win;
    res     = fld_zx;
    flag    = old_lj;
    case (op)
      OP_EXTS: res = fld_sx;
      OP_INS: begin
        new_win = (win & ~mask) | ins_bits;
        flag    = val << rsh;
      end
      OP_CHG: new_win = win ^ mask;
      OP_CLR: new_win = win & ~mask;
      OP_SET: new_win = win | mask;
      OP_FFO: res = ofs + FIELD_W'((old_lj == '0) ? len : lead);
      default: res = fld_zx;
    endcase
  end
endmodule

// File: rtl/bfm_unit.sv
module bfm_unit
  import bfm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [FIELD_W-1:0] cmd_ofs,
  input  logic [LEN_W-2:0]   cmd_width,
  input  logic [FIELD_W-1:0] cmd_val,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  output logic [1:0]         rd_req_size,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [WIN_W-1:0]   rd_rsp_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [FIELD_W-1:0] res_data,
  output logic [FIELD_W-1:0] res_flag,
  output logic               res_wb_en,
  output logic [ADDR_W-1:0]  res_wb_addr,
  output logic [1:0]         res_wb_size,
  output logic [WIN_W-1:0]   res_wb_data
);
  bf_state_t          state_q;
  bf_op_t             op_q;
  logic [FIELD_W-1:0] ofs_q, val_q;
  bf_geom_t           geom_now, geom_q;
  logic [WIN_W-1:0]   size_mask, win_in;
  logic [WIN_W-1:0]   alu_win;
  logic [FIELD_W-1:0] alu_res, alu_flag;
  logic [WIN_W-1:0]   wb_q;
  logic [FIELD_W-1:0] res_q, flag_q;

  bfm_geom geom_i (
    .base_addr (cmd_addr),
    .bit_ofs   (cmd_ofs),
    .width     (cmd_width),
    .geom      (geom_now)
  );

  always_comb begin
    case (geom_q.size)
      2'd0:    size_mask = WIN_W'({8{1'b1}});
      2'd1:    size_mask = WIN_W'({16{1'b1}});
      2'd2:    size_mask = WIN_W'({32{1'b1}});
      default: size_mask = '1;
    endcase
    win_in = rd_rsp_data & size_mask;
  end

  bfm_alu alu_i (
    .op      (op_q),
    .wofs    (geom_q.wofs),
    .len     (geom_q.len),
    .win     (win_in),
    .val     (val_q),
    .ofs     (ofs_q),
    .new_win (alu_win),
    .res     (alu_res),
    .flag    (alu_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_EXTU;
      ofs_q   <= '0;
      val_q   <= '0;
      geom_q  <= '0;
      wb_q    <= '0;
      res_q   <= '0;
      flag_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= bf_op_t'(cmd_op);
          ofs_q   <= cmd_ofs;
          val_q   <= cmd_val;
          geom_q  <= geom_now;
          state_q <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state_q <= ST_RSP;
        ST_RSP: if (rd_rsp_valid) begin
          wb_q    <= alu_win;
          res_q   <= alu_res;
          flag_q  <= alu_flag;
          state_q <= ST_OUT;
        end
        default: if (res_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state_q == ST_IDLE);
  assign rd_req_valid = (state_q == ST_REQ);
  assign rd_rsp_ready = (state_q == ST_RSP);
  assign res_valid    = (state_q == ST_OUT);
  assign rd_req_addr  = geom_q.addr;
  assign rd_req_size  = geom_q.size;
  assign res_wb_addr  = geom_q.addr;
  assign res_wb_size  = geom_q.size;
  assign res_wb_data  = wb_q;
  assign res_data     = res_q;
  assign res_flag     = flag_q;
  assign res_wb_en    = (op_q == OP_INS) || (op_q == OP_CHG) ||
                        (op_q == OP_CLR) || (op_q == OP_SET);
endmodule

// File: rtl/bfm_unit_chk.sv
module bfm_unit_chk
  import bfm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic [1:0]         rd_req_size,
  input logic               rd_rsp_valid,
  input logic               rd_rsp_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [FIELD_W-1:0] res_data,
  input logic [FIELD_W-1:0] res_flag,
  input logic               res_wb_en,
  input logic [1:0]         res_wb_size,
  input logic [WIN_W-1:0]   res_wb_data
);
  p_one_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, rd_req_valid, rd_rsp_ready, res_valid}));

  p_cmd_to_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rd_req_valid);

  p_rsp_to_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_ready |=> res_valid);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=>
      rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_size));

  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=>
      res_valid && $stable(res_data) && $stable(res_flag) &&
      $stable(res_wb_en) && $stable(res_wb_data));

  p_long_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_size == 2'd3 |-> rd_req_addr[1:0] == 2'b00);

  p_wb_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wb_size != 2'd3 |-> res_wb_data[WIN_W-1:FIELD_W] == '0);
endmodule

bind bfm_unit bfm_unit_chk chk_i (.*);

// File: tb/bfm_unit_tb_top.sv
module bfm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_ofs = '0;
  logic [4:0]  cmd_width = '0;
  logic [31:0] cmd_val = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic [1:0]  rd_req_size;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [63:0] rd_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_data, res_flag;
  logic        res_wb_en;
  logic [31:0] res_wb_addr;
  logic [1:0]  res_wb_size;
  logic [63:0] res_wb_data;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];

  always #5 clk = ~clk;

  bfm_unit dut_i (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int base, input int ofs,
                        input int w, input logic [31:0] val, input int k);
    int len, bofs, nb, lz, nbytes;
    longint p0, pos, start;
    logic [31:0] fld, sx, ffo, exp_res, exp_flag, a0;
    logic [63:0] ones, win;
    logic [31:0] exp_addr;
    logic [1:0]  exp_size;
    logic [31:0] got_res, got_flag, got_addr;
    logic        got_en;
    logic [1:0]  got_size;
    logic [63:0] got_win;
    bit found;
    string tag;

    len = (w == 0) ? 32 : w;
    p0  = longint'(base) * 8 + longint'(ofs);
    fld = '0;
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < len; i++) begin
      pos = p0 + i;
      fld = {fld[30:0], mem[int'((pos >> 3) & 63)][7 - int'(pos & 7)]};
    end
    for (int i = 0; i < len; i++) begin
      int bi, bb;
      pos = p0 + i;
      bi = int'((pos >> 3) & 63);
      bb = 7 - int'(pos & 7);
      case (op)
        2: exp_mem[bi][bb] = val[len - 1 - i];
        3: exp_mem[bi][bb] = ~exp_mem[bi][bb];
        4: exp_mem[bi][bb] = 1'b0;
        5: exp_mem[bi][bb] = 1'b1;
        default: ;
      endcase
    end
    start = p0 >> 3;
    bofs  = int'(p0 & 7);
    nb    = (bofs + len - 1) / 8 + 1;
    exp_addr = 32'(start);
    case (nb)
      1: exp_size = 2'd0;
      2: exp_size = 2'd1;
      3: begin exp_size = 2'd2; if (exp_addr[0]) exp_addr = exp_addr - 1; end
      4: exp_size = 2'd2;
      default: begin exp_size = 2'd3; exp_addr[1:0] = 2'b00; end
    endcase
    ones = (64'd1 << len) - 1;
    sx = (fld[len-1]) ? (fld | ~ones[31:0]) : fld;
    lz = 0; found = 0;
    for (int i = 0; i < len; i++) begin
      if (!found) begin
        if (fld[len - 1 - i]) found = 1; else lz++;
      end
    end
    ffo = 32'(ofs) + 32'(lz);
    exp_flag = (op == 2) ? (val << (32 - len)) : (fld << (32 - len));
    case (op)
      0: exp_res = sx;
      6: exp_res = ffo;
      default: exp_res = fld;
    endcase

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = 32'(base);
    cmd_ofs = 32'(ofs); cmd_width = 5'(w); cmd_val = val;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R8 busy", 64'(cmd_ready), 64'd0);
    while (!rd_req_valid) @(negedge clk);
    check({rd_req_addr, rd_req_size} == {exp_addr, exp_size}, "R2/R3 window",
          64'({rd_req_addr, rd_req_size}), 64'({exp_addr, exp_size}));
    a0 = rd_req_addr;
    repeat (k) @(negedge clk);
    check(rd_req_valid && rd_req_addr == a0, "R8 req hold", 64'(rd_req_addr), 64'(a0));
    nbytes = 1 << rd_req_size;
    win = '0;
    for (int j = 0; j < nbytes; j++) win = {win[55:0], mem[int'(rd_req_addr[5:0]) + j]};
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    repeat (k) @(negedge clk);
    rd_rsp_valid = 1'b1; rd_rsp_data = win;
    while (!rd_rsp_ready) @(negedge clk);
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat (k) @(negedge clk);
    got_res = res_data; got_flag = res_flag; got_en = res_wb_en;
    got_addr = res_wb_addr; got_size = res_wb_size; got_win = res_wb_data;
    case (op)
      0: tag = "R4 sext";
      1, 7: tag = (w == 0) ? "R1 width0" : "R4 zext";
      6: tag = "R7 ffo";
      default: tag = "R10 old field";
    endcase
    check(got_res == exp_res, tag, 64'(got_res), 64'(exp_res));
    check(got_flag == exp_flag, (op == 2) ? "R5 flag" : "R10 flag",
          64'(got_flag), 64'(exp_flag));
    check(got_en == (op >= 2 && op <= 5) && got_addr == exp_addr && got_size == exp_size,
          "R9 wb ctl", 64'({got_en, got_addr, got_size}),
          64'({(op >= 2 && op <= 5), exp_addr, exp_size}));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    if (got_en) begin
      for (int j = 0; j < nbytes; j++)
        mem[int'(got_addr[5:0]) + j] = got_win[8*(nbytes - 1 - j) +: 8];
    end
    begin
      bit same;
      same = 1;
      for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) same = 0;
      check(same, (op == 2) ? "R5 memory" : "R6 memory", 64'(same), 64'd1);
    end
  endtask

  initial begin
    int idx;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !rd_req_valid && !res_valid && !rd_rsp_ready, "R8 reset",
          64'({cmd_ready, rd_req_valid, rd_rsp_ready, res_valid}), 64'b1000);
    idx = 0;
    for (int op = 0; op < 8; op++) begin
      for (int w = 0; w < 32; w++) begin
        for (int ofs = -20; ofs <= 20; ofs++) begin
          if (op == 7 && (ofs % 4) != 0) continue;
          for (int i = 0; i < 64; i++)
            mem[i] = (idx % 6 == 0) ? 8'h00 : 8'((i * 37 + idx * 11 + 5) & 255);
          run_op(op, 32'h1020 + ((w + op + ofs) & 3), ofs, w,
                 32'hA5C3_9E17 ^ 32'(idx * 40503), idx % 3);
          idx++;
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule